// File: doc/BRIEF.md
# Single-Word Mailbox Channel Bank

This block carries 32-bit words from a sending processor to a receiving processor over eight independent channels. Each channel is a single word register. Writing it is the whole event: the store also raises that channel's pending flag in a shared status word. No separate doorbell write is needed. The receiving processor sees the pending flags in the status word. It gates them with a per-bit interrupt enable mask, which drives one receive interrupt line. It acknowledges a channel by writing a one to that bit of a clear register and then fetches the word. The sending side is never interrupted.

Access uses a plain 32-bit register bus with a byte address, a write strobe, write data, a read strobe and registered read data. The channel words, the status word, the clear register and the enable mask each have a fixed offset. The pending flags start at bit 9 of the status word, so that the enable and clear registers share the same bit layout.

Top module: `fastmbox_bank`

## Requirements
- R1: After reset every channel word, every pending flag and every enable bit is zero, and `rx_irq` and `bus_rdata` are 0.
- R2: A write to byte offset 0x8C + 4*n (n = 0..7) stores `bus_wdata` in channel n. A later read of that offset returns the stored word.
- R3: A write to channel n sets bit n+9 of the status word. The status word is read at offset 0xC8, and all of its other bits read as 0.
- R4: Writing to offset 0xC4 clears exactly the pending flags whose bits are 1 in `bus_wdata`. Pending flags whose bits are 0 are left as they were.
- R5: The enable mask is written and read at offset 0xC0. Only bits 9..16 are stored, and every other bit reads as 0.
- R6: `rx_irq` is a register that goes high on the clock edge after any pending flag and its enable bit are both 1. It goes low on the clock edge after no such pair remains.
- R7: A channel word holds its value until that channel is written again. Clearing its pending flag does not change it.
- R8: `bus_rdata` takes the value of the addressed register on the clock edge at which `bus_re` is high. Offsets that map to no readable register return 0. While `bus_re` is low, `bus_rdata` holds its value.
- R9: Writes to the status offset 0xC8 or to an unmapped offset change no channel word, pending flag or enable bit.
- R10: Writing a channel again while its flag is pending replaces the word and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rx_irq | output | 1 | Registered receive interrupt |

## Verification
A write takes effect on the edge where its strobe is sampled, so a read issued in the next cycle already sees the new word, flag or mask. Read data is due one edge after the read strobe. The scoreboard monitor therefore records the strobe at the rising edge and compares `bus_rdata` at the following falling edge. The interrupt lags its causes by one extra edge. The bench samples `rx_irq` once right after the enabling or clearing write, when it must still hold its old level, and once a cycle later, when it must have changed.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  localparam int FMB_NCH       = 8;
  localparam int FMB_DW        = 32;
  localparam int FMB_AW        = 8;
  localparam int FMB_CH_BASE   = 'h8C;
  localparam int FMB_EN_ADDR   = 'hC0;
  localparam int FMB_CLR_ADDR  = 'hC4;
  localparam int FMB_STAT_ADDR = 'hC8;
  localparam int FMB_PEND_LSB  = 9;
endpackage

// File: rtl/fmb_chan_store.sv
module fmb_chan_store #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          wr_hit,
  input  logic [DW-1:0]           wdata,
  output logic [NCH-1:0][DW-1:0]  data_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)            data_q[i] <= '0;
      else if (wr_hit[i]) data_q[i] <= wdata;
    end

    // word changes only when its own channel is written
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[i] |=> $stable(data_q[i]));
    assert_word_store_R2: assert property (@(posedge clk) disable iff (rst)
      wr_hit[i] |=> data_q[i] == $past(wdata));
  end
endmodule

// File: rtl/fmb_pend_ctl.sv
module fmb_pend_ctl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_hit,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  input  logic           en_we,
  input  logic [NCH-1:0] en_mask,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] en_q,
  output logic           irq_q
);
  logic [NCH-1:0] clr_eff;
  logic [NCH-1:0] pend_d;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    // a set in the same cycle overrides a clear
    pend_d  = (pend_q & ~clr_eff) | set_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= en_mask;
      irq_q  <= |(pend_q & en_q);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_set_pending_R3: assert property (@(posedge clk) disable iff (rst)
      set_hit[i] |=> pend_q[i]);
    assert_clear_one_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !set_hit[i]) |=> !pend_q[i]);
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (!set_hit[i] && !(clr_we && clr_mask[i])) |=> $stable(pend_q[i]));
  end

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & en_q)) |=> irq_q);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_q & en_q)) |=> !irq_q);
endmodule

// File: rtl/fmb_read_port.sv
module fmb_read_port #(
  parameter int NCH       = 8,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int CH_BASE   = 'h8C,
  parameter int EN_ADDR   = 'hC0,
  parameter int STAT_ADDR = 'hC8,
  parameter int PEND_LSB  = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic                   re,
  input  logic [NCH-1:0][DW-1:0] data_q,
  input  logic [NCH-1:0]         pend_q,
  input  logic [NCH-1:0]         en_q,
  output logic [DW-1:0]          rdata_q
);
  localparam logic [AW-1:0] EN_A   = AW'(EN_ADDR);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (addr == STAT_A) rd_val[PEND_LSB +: NCH] = pend_q;
    if (addr == EN_A)   rd_val[PEND_LSB +: NCH] = en_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(CH_BASE + 4 * i)) rd_val = data_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rd_val;
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata_q));
endmodule

// File: rtl/fastmbox_bank.sv
module fastmbox_bank
  import fmb_pkg::*;
#(
  parameter int NCH       = FMB_NCH,
  parameter int DW        = FMB_DW,
  parameter int AW        = FMB_AW,
  parameter int CH_BASE   = FMB_CH_BASE,
  parameter int EN_ADDR   = FMB_EN_ADDR,
  parameter int CLR_ADDR  = FMB_CLR_ADDR,
  parameter int STAT_ADDR = FMB_STAT_ADDR,
  parameter int PEND_LSB  = FMB_PEND_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_irq
);
  localparam logic [AW-1:0] EN_A  = AW'(EN_ADDR);
  localparam logic [AW-1:0] CLR_A = AW'(CLR_ADDR);

  logic [NCH-1:0]          wr_hit;
  logic [NCH-1:0][DW-1:0]  data_q;
  logic [NCH-1:0]          pend_q;
  logic [NCH-1:0]          en_q;
  logic                    clr_we;
  logic                    en_we;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [AW-1:0] CH_A = AW'(CH_BASE + 4 * i);
    assign wr_hit[i] = bus_we && (bus_addr == CH_A);
  end
  assign clr_we = bus_we && (bus_addr == CLR_A);
  assign en_we  = bus_we && (bus_addr == EN_A);

  fmb_chan_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(bus_wdata), .data_q(data_q)
  );

  fmb_pend_ctl #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .set_hit(wr_hit),
    .clr_we(clr_we), .clr_mask(bus_wdata[PEND_LSB +: NCH]),
    .en_we(en_we), .en_mask(bus_wdata[PEND_LSB +: NCH]),
    .pend_q(pend_q), .en_q(en_q), .irq_q(rx_irq)
  );

  fmb_read_port #(
    .NCH(NCH), .DW(DW), .AW(AW), .CH_BASE(CH_BASE),
    .EN_ADDR(EN_ADDR), .STAT_ADDR(STAT_ADDR), .PEND_LSB(PEND_LSB)
  ) u_read (
    .clk(clk), .rst(rst), .addr(bus_addr), .re(bus_re),
    .data_q(data_q), .pend_q(pend_q), .en_q(en_q), .rdata_q(bus_rdata)
  );

  // at most one channel decoded per write
  assert_one_channel_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
  // untouched registers keep their state
  assert_no_side_write_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(en_q) && $stable(data_q)));
endmodule

// File: tb/test_fastmbox_bank.sv
module test_fastmbox_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        rx_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_data [8];
  logic [31:0] m_stat;
  logic [31:0] m_en;

  always #5 clk = ~clk;

  fastmbox_bank i_fastmbox_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_irq(rx_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ch_addr(input int n);
    return 8'(8'h8C + 4 * n);
  endfunction

  // driver: write one word and update the model
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    for (int i = 0; i < 8; i++)
      if (a == ch_addr(i)) begin m_data[i] = d; m_stat[i+9] = 1'b1; end
    if (a == 8'hC4) m_stat = m_stat & ~(d & 32'h0001_FE00);
    if (a == 8'hC0) m_en = d & 32'h0001_FE00;
  endtask

  // driver: issue a read and push the expected word
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: read data is due one edge after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R8: unexpected read data %08h expected none", bus_rdata);
        end else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    m_stat = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(bus_rdata, 32'h0, "R1 rdata");
    chk({31'b0, rx_irq}, 32'h0, "R1 irq");
    for (int i = 0; i < 8; i++) rd(ch_addr(i), 32'h0, "R1 data");
    rd(8'hC8, 32'h0, "R1 status");
    rd(8'hC0, 32'h0, "R1 enable");

    // R2/R3 writes store words and raise flags
    wr(ch_addr(0), 32'hA5A5_0001);
    wr(ch_addr(7), 32'hDEAD_BEEF);
    wr(ch_addr(3), 32'h1234_5678);
    rd(ch_addr(0), 32'hA5A5_0001, "R2 ch0");
    rd(ch_addr(7), 32'hDEAD_BEEF, "R2 ch7");
    rd(ch_addr(3), 32'h1234_5678, "R2 ch3");
    rd(8'hC8, 32'h0001_1200, "R3 status bits 9,12,16");
    chk({31'b0, rx_irq}, 32'h0, "R6 irq masked");

    // R5 enable mask keeps only bits 9..16
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h0001_FE00, "R5 enable all");
    wr(8'hC0, 32'h0000_1001);
    chk({31'b0, rx_irq}, 32'h1, "R6 irq old level");
    rd(8'hC0, 32'h0000_1000, "R5 enable ch3");
    idle(1);
    chk({31'b0, rx_irq}, 32'h1, "R6 irq from ch3");

    // R4 clear only bits written as one
    wr(8'hC4, 32'h0000_0000);
    rd(8'hC8, m_stat, "R4 zero mask no effect");
    wr(8'hC4, 32'h0000_0200);
    rd(8'hC8, 32'h0001_1000, "R4 clear ch0 only");
    chk({31'b0, rx_irq}, 32'h1, "R6 irq stays");
    wr(8'hC4, 32'h0000_1000);
    chk({31'b0, rx_irq}, 32'h1, "R6 irq fall lags");
    idle(1);
    chk({31'b0, rx_irq}, 32'h0, "R6 irq dropped");
    rd(ch_addr(3), 32'h1234_5678, "R7 word kept after clear");

    // R9 writes with no target
    wr(8'hC8, 32'hFFFF_FFFF);
    rd(8'hC8, 32'h0001_0000, "R9 status write ignored");
    wr(8'h10, 32'hCAFE_F00D);
    rd(8'h10, 32'h0, "R8 unmapped reads zero");
    rd(8'hC4, 32'h0, "R8 clear reg reads zero");
    for (int i = 0; i < 8; i++) rd(ch_addr(i), m_data[i], "R9 words unchanged");
    rd(8'hC0, 32'h0000_1000, "R9 enable unchanged");

    // R10 overwrite while pending
    wr(ch_addr(7), 32'h0BAD_F00D);
    rd(ch_addr(7), 32'h0BAD_F00D, "R10 new word");
    rd(8'hC8, 32'h0001_0000, "R10 flag kept");

    // R8 rdata holds while strobe low
    idle(4);
    chk(bus_rdata, 32'h0001_0000, "R8 rdata hold");

    // R6 irq with an enable change and a new channel
    wr(8'hC0, 32'h0001_0000);
    idle(1);
    chk({31'b0, rx_irq}, 32'h1, "R6 irq from ch7");
    wr(ch_addr(5), 32'h5555_AAAA);
    rd(8'hC8, m_stat, "R3 status ch5 ch7");
    rd(ch_addr(0), 32'hA5A5_0001, "R7 ch0 held");

    idle(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: actual %0d reads pending expected 0", exp_q.size());
    end
    done = 1;
    report();
  end
endmodule